// File: doc/BRIEF.md
# Dual-Channel Registered Bus Transceiver

This block passes byte-wide data between two ports, called A and B, in either direction. Each transfer direction has its own storage register, and a select line picks what the driving port sends. It can send the live value on the opposite port, or the value that register captured earlier. Each channel has these controls:

- an active-low output enable
- a direction input
- two capture strobes, one per direction
- two source selects

A parameter sets how many independent channels are placed side by side. The default is two channels of eight bits each.

Bidirectional pins are modelled as three parts: an input vector, an output vector and a drive-enable bit per port. A bus-hold register on every port keeps the last level seen on it. While the port is undriven, its output vector shows that held level. An external-driver flag per port tells the keeper when the input side carries a real value that it should follow. Capture strobes and bus-hold registers are sampled on a single core clock. A capture happens at the first clock edge where a strobe is seen high after being low.

Top module: `dual_bus_xcvr`

## Requirements
- R1: With a channel's enable input high, neither `a_drv` nor `b_drv` of that channel is asserted.
- R2: With the enable low, direction 0 asserts `a_drv` only and direction 1 asserts `b_drv` only.
- R3: With A driving and `sel_ba` = 0, `a_out` equals the live `b_in` of the channel in the same cycle.
- R4: With A driving and `sel_ba` = 1, `a_out` equals the B storage register of the channel.
- R5: With B driving, `b_out` equals the live `a_in` when `sel_ab` = 0, and the A storage register when `sel_ab` = 1.
- R6: A capture strobe seen high at a clock edge after being low at the previous edge loads that port's input into its storage register at that edge. This happens whatever the enable and direction inputs are.
- R7: A capture strobe held high over further edges does not reload the storage register.
- R8: An undriven port's output shows the value that port last drove, held by the bus-hold register.
- R9: On an undriven port whose external-driver flag is high, the bus-hold register takes the port input at each clock edge.
- R10: An asynchronous low `rst_n` clears both storage registers and both bus-hold registers of every channel to zero.
- R11: Channels are independent: one channel's controls and stored data never change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock sampling strobes and updating bus hold |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | NUM_CH | Active-low output enable per channel |
| dir | input | NUM_CH | 0: A port drives, 1: B port drives |
| cap_ab | input | NUM_CH | Capture strobe for the A storage register |
| cap_ba | input | NUM_CH | Capture strobe for the B storage register |
| sel_ab | input | NUM_CH | B-side source: 0 live A, 1 stored A |
| sel_ba | input | NUM_CH | A-side source: 0 live B, 1 stored B |
| a_ext | input | NUM_CH | External driver present on A port |
| b_ext | input | NUM_CH | External driver present on B port |
| a_in | input | NUM_CH*CH_W | A port input level, channel c at bits c*CH_W upward |
| b_in | input | NUM_CH*CH_W | B port input level |
| a_out | output | NUM_CH*CH_W | A port output level (held value when undriven) |
| b_out | output | NUM_CH*CH_W | B port output level (held value when undriven) |
| a_drv | output | NUM_CH | A port drive enable |
| b_drv | output | NUM_CH | B port drive enable |

## Verification
The hardest state to reach from the ports is a storage register holding something other than the current input while its strobe stays high. The stimulus raises the strobe with one value present and then changes the input over several edges before the strobe drops. The same stored value is then read out through the stored path after isolation. Bus hold needs an undriven port whose held value differs from everything now on the inputs. To get there, the bench drives a value, isolates the port, zeroes the opposite input, and then lets an external driver overwrite the hold.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;

   typedef enum logic {
      DIR_TO_A = 1'b0,
      DIR_TO_B = 1'b1
   } dir_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic strobe_q;
   logic rise;

   if (W < 1) begin : g_chk_w
      $error("xcvr_capture_reg: W must be at least 1");
   end

   assign rise = strobe & ~strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         q        <= '0;
      end else begin
         strobe_q <= strobe;
         if (rise) q <= din;
      end
   end

   AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && $rose(strobe)) |=> (q == $past(din))); // R6

   AST_HELD_STROBE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && strobe && $past(strobe) && $past(rst_n)) |=> $stable(q)); // R7
endmodule

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
   parameter int W       = 8,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         drive,
   input  logic [W-1:0] drive_val,
   input  logic         ext_en,
   input  logic [W-1:0] ext_val,
   output logic [W-1:0] pin_out
);
   if (W < 1) begin : g_chk_w
      $error("xcvr_bus_keeper: W must be at least 1");
   end

   if (HOLD_EN) begin : g_hold
      logic [W-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (drive) begin
            hold_q <= drive_val;
         end else if (ext_en) begin
            hold_q <= ext_val;
         end
      end

      assign pin_out = drive ? drive_val : hold_q;

      AST_HOLD_TRACKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && drive) |=> (hold_q == $past(drive_val))); // R8

      AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && !drive && !ext_en) |=> $stable(hold_q)); // R8

      AST_HOLD_FOLLOWS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && !drive && ext_en) |=> (hold_q == $past(ext_val))); // R9
   end else begin : g_nohold
      assign pin_out = drive ? drive_val : '0;
   end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int W       = 8,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         oe_n,
   input  logic         dir,
   input  logic         cap_ab,
   input  logic         cap_ba,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic         a_ext,
   input  logic         b_ext,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] b_out,
   output logic         a_drv,
   output logic         b_drv
);
   logic [W-1:0] store_a;
   logic [W-1:0] store_b;
   logic [W-1:0] to_a;
   logic [W-1:0] to_b;
   dir_e         dir_s;
   src_sel_e     src_ab;
   src_sel_e     src_ba;

   assign dir_s  = dir_e'(dir);
   assign src_ab = src_sel_e'(sel_ab);
   assign src_ba = src_sel_e'(sel_ba);

   assign a_drv = ~oe_n & (dir_s == DIR_TO_A);
   assign b_drv = ~oe_n & (dir_s == DIR_TO_B);

   xcvr_capture_reg #(.W(W)) u_cap_a (
      .clk(clk), .rst_n(rst_n), .strobe(cap_ab), .din(a_in), .q(store_a)
   );

   xcvr_capture_reg #(.W(W)) u_cap_b (
      .clk(clk), .rst_n(rst_n), .strobe(cap_ba), .din(b_in), .q(store_b)
   );

   always_comb begin
      to_a = (src_ba == SRC_STORED) ? store_b : b_in;
      to_b = (src_ab == SRC_STORED) ? store_a : a_in;
   end

   xcvr_bus_keeper #(.W(W), .HOLD_EN(HOLD_EN)) u_keep_a (
      .clk(clk), .rst_n(rst_n), .drive(a_drv), .drive_val(to_a),
      .ext_en(a_ext), .ext_val(a_in), .pin_out(a_out)
   );

   xcvr_bus_keeper #(.W(W), .HOLD_EN(HOLD_EN)) u_keep_b (
      .clk(clk), .rst_n(rst_n), .drive(b_drv), .drive_val(to_b),
      .ext_en(b_ext), .ext_val(b_in), .pin_out(b_out)
   );

   AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_drv, b_drv})); // R2

   AST_ENABLED_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> ($countones({a_drv, b_drv}) == 1)); // R2

   AST_ISOLATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!a_drv && !b_drv)); // R1
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
   parameter int NUM_CH  = 2,
   parameter int CH_W    = 8,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        oe_n,
   input  logic [NUM_CH-1:0]        dir,
   input  logic [NUM_CH-1:0]        cap_ab,
   input  logic [NUM_CH-1:0]        cap_ba,
   input  logic [NUM_CH-1:0]        sel_ab,
   input  logic [NUM_CH-1:0]        sel_ba,
   input  logic [NUM_CH-1:0]        a_ext,
   input  logic [NUM_CH-1:0]        b_ext,
   input  logic [NUM_CH*CH_W-1:0]   a_in,
   input  logic [NUM_CH*CH_W-1:0]   b_in,
   output logic [NUM_CH*CH_W-1:0]   a_out,
   output logic [NUM_CH*CH_W-1:0]   b_out,
   output logic [NUM_CH-1:0]        a_drv,
   output logic [NUM_CH-1:0]        b_drv
);
   localparam int BUS_W = NUM_CH * CH_W;

   if (NUM_CH < 1) begin : g_chk_ch
      $error("dual_bus_xcvr: NUM_CH must be at least 1");
   end
   if (CH_W < 1 || BUS_W > 4096) begin : g_chk_w
      $error("dual_bus_xcvr: CH_W out of range");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      xcvr_lane #(.W(CH_W), .HOLD_EN(HOLD_EN)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .oe_n   (oe_n[c]),
         .dir    (dir[c]),
         .cap_ab (cap_ab[c]),
         .cap_ba (cap_ba[c]),
         .sel_ab (sel_ab[c]),
         .sel_ba (sel_ba[c]),
         .a_ext  (a_ext[c]),
         .b_ext  (b_ext[c]),
         .a_in   (a_in[c*CH_W +: CH_W]),
         .b_in   (b_in[c*CH_W +: CH_W]),
         .a_out  (a_out[c*CH_W +: CH_W]),
         .b_out  (b_out[c*CH_W +: CH_W]),
         .a_drv  (a_drv[c]),
         .b_drv  (b_drv[c])
      );
   end
endmodule

// File: tb/tb_dual_bus_xcvr.sv
module tb_dual_bus_xcvr;
   localparam int NCH = 2;
   localparam int W   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] oe_n = '1, dir = '0, cap_ab = '0, cap_ba = '0;
   logic [NCH-1:0] sel_ab = '0, sel_ba = '0, a_ext = '0, b_ext = '0;
   logic [NCH*W-1:0] a_in = '0, b_in = '0;
   logic [NCH*W-1:0] a_out, b_out;
   logic [NCH-1:0] a_drv, b_drv;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dual_bus_xcvr #(.NUM_CH(NCH), .CH_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab),
      .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba), .a_ext(a_ext),
      .b_ext(b_ext), .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
      .a_drv(a_drv), .b_drv(b_drv)
   );

   // {oe_n, dir, sel_ab, sel_ba, a_in[7:0], b_in[7:0], exp_a_drv, exp_b_drv, exp_driven_out[7:0]}
   localparam logic [29:0] VEC [6] = '{
      {1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34, 1'b0, 1'b0, 8'h00}, // R1 isolated
      {1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h5A, 1'b1, 1'b0, 8'h5A}, // R2 R3 live B to A
      {1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 8'h5A, 1'b1, 1'b0, 8'hA5}, // R4 stored B to A
      {1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 8'h5A, 1'b0, 1'b1, 8'h81}, // R2 R5 live A to B
      {1'b0, 1'b1, 1'b1, 1'b0, 8'h81, 8'h5A, 1'b0, 1'b1, 8'h3C}, // R5 R7 stored A to B
      {1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 8'h5A, 1'b0, 1'b0, 8'h00}  // R1 isolated again
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #23;
      rst_n = 1'b1;
      step();
      // R10: reset state, outputs undriven and holding zero
      chk("R10 a_out after reset", a_out, 0);
      chk("R10 b_out after reset", b_out, 0);
      chk("R1 no drive after reset", {a_drv, b_drv}, 0);

      // R6/R7: capture into A store while isolated; strobe held high over new data
      a_in[7:0] = 8'h3C;
      cap_ab[0] = 1'b1;
      step();
      a_in[7:0] = 8'h11;
      step();
      step();
      cap_ab[0] = 1'b0;
      // R6: capture into B store while isolated
      b_in[7:0] = 8'hA5;
      cap_ba[0] = 1'b1;
      step();
      cap_ba[0] = 1'b0;
      b_in[7:0] = 8'h00;
      step();

      for (int i = 0; i < 6; i++) begin
         logic [29:0] v;
         v = VEC[i];
         oe_n[0] = v[29];
         dir[0] = v[28];
         sel_ab[0] = v[27];
         sel_ba[0] = v[26];
         a_in[7:0] = v[25:18];
         b_in[7:0] = v[17:10];
         #1;
         chk("R1/R2 a_drv table", a_drv[0], v[9]);
         chk("R1/R2 b_drv table", b_drv[0], v[8]);
         if (v[9]) chk("R3/R4 a_out table", a_out[7:0], v[7:0]);
         if (v[8]) chk("R5 b_out table", b_out[7:0], v[7:0]);
         chk("R11 other channel idle", {a_drv[1], b_drv[1]}, 0);
         step();
      end

      // R8: drive 77 onto A, then isolate and remove the source
      oe_n[0] = 1'b0; dir[0] = 1'b0; sel_ba[0] = 1'b0; b_in[7:0] = 8'h77;
      step();
      oe_n[0] = 1'b1; b_in[7:0] = 8'h00;
      #1;
      chk("R1 a_drv isolated", a_drv[0], 0);
      chk("R8 a_out holds last driven", a_out[7:0], 8'h77);
      step();
      chk("R8 hold survives edges", a_out[7:0], 8'h77);

      // R9: external driver overwrites hold at the next edge
      a_ext[0] = 1'b1; a_in[7:0] = 8'h42;
      #1;
      chk("R9 hold unchanged before edge", a_out[7:0], 8'h77);
      step();
      a_ext[0] = 1'b0; a_in[7:0] = 8'h99;
      #1;
      chk("R9 hold follows external input", a_out[7:0], 8'h42);

      // R11: channel 1 capture and drive, channel 0 store untouched
      a_in[15:8] = 8'hE7; cap_ab[1] = 1'b1;
      step();
      cap_ab[1] = 1'b0; a_in[15:8] = 8'h00;
      oe_n[1] = 1'b0; dir[1] = 1'b1; sel_ab[1] = 1'b1;
      oe_n[0] = 1'b0; dir[0] = 1'b1; sel_ab[0] = 1'b1;
      #1;
      chk("R11 ch1 stored A", b_out[15:8], 8'hE7);
      chk("R11 ch0 stored A unchanged", b_out[7:0], 8'h3C);
      chk("R2 ch1 b drives", {a_drv[1], b_drv[1]}, 2'b01);

      // R6: capture while channel 0 drives B from the store
      a_in[7:0] = 8'hC3; cap_ab[0] = 1'b1;
      #1;
      chk("R6 store not loaded before edge", b_out[7:0], 8'h3C);
      step();
      cap_ab[0] = 1'b0;
      #1;
      chk("R6 store loaded at edge", b_out[7:0], 8'hC3);

      // R10: asynchronous reset clears holds and stores
      oe_n = '1;
      step();
      rst_n = 1'b0;
      #1;
      chk("R10 holds cleared A", a_out, 0);
      chk("R10 holds cleared B", b_out, 0);
      step();
      rst_n = 1'b1;
      oe_n[0] = 1'b0; dir[0] = 1'b1; sel_ab[0] = 1'b1;
      #1;
      chk("R10 store A cleared", b_out[7:0], 8'h00);
      dir[0] = 1'b0; sel_ba[0] = 1'b1;
      #1;
      chk("R10 store B cleared", a_out[7:0], 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule